// File: doc/BRIEF.md
# USB Host Interrupt Enable and Request Gating

This block holds the interrupt enable register of a USB host controller, together with the six sticky status flags it guards and the logic that folds both into a single level-sensitive interrupt request. The DMA engine, the schedule walker and the port logic each report events as single-cycle pulses on `evt_i`. Every pulse sets its status flag, and the flag stays set until software writes a one to it through the 32-bit register port.

The sources fall into two classes. Port change, frame list rollover and host system error raise the request as soon as their flag and enable are both set. Transaction complete, bus error and async advance wait: an enabled flag in this class is promoted onto the request line only when the interrupt-threshold strobe `thresh_i` pulses. After promotion the request holds without further strobes until every enabled deferred flag is gone. The request output is registered.

Top module: `usb_host_irq_ctrl`

## Requirements
- R1: The enable register is at word address 1 and the status register at word address 0. Both use the same bit positions: 0 transaction complete, 1 bus error, 2 port change, 3 frame list rollover, 4 host system error, 5 async advance. The `evt_i` bits use the same order. A write to address 1 stores bits 5..0 and a read returns them.
- R2: Bits 31 to 6 of both registers read as zero. After reset, all enables and status flags are zero and `irq_o` is low.
- R3: `irq_o` is asserted only while at least one status flag and its matching enable are both set. Setting a flag whose enable is clear leaves `irq_o` low. Clearing the enable drops `irq_o` one cycle later, and the status flag is kept.
- R4: A pulse on `evt_i[k]` sets status bit k on the next clock edge, and the bit stays set. Writing a 1 to status bit k clears it. Writing 0 leaves it unchanged. When a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Deferred sources (bits 0, 1, 5) leave `irq_o` low until a `thresh_i` pulse arrives in a cycle in which an enabled deferred flag is already set. `irq_o` then rises on that edge. A strobe in the same cycle as the event pulse does not promote that event.
- R6: Immediate sources (bits 2, 3, 4) raise `irq_o` one cycle after their enabled status flag becomes visible, which is two clock edges after the event pulse, with no strobe needed.
- R7: Once raised, `irq_o` stays high without further strobes while its cause stays enabled and set. It falls one clock edge after the clearing write takes effect.
- R8: After a promoted deferred flag has been cleared, a new event of that class needs a new `thresh_i` pulse before `irq_o` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Single-cycle event pulses, one per source |
| thresh_i | input | 1 | Interrupt-threshold strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each immediate source is enabled alone and pulsed. The request has to wait exactly two edges and then hold until it is cleared, which separates the immediate class from the deferred one and a registered output from a combinational one. Each deferred source is pulsed and left idle for several cycles before the strobe, which shows that promotion waits for the strobe. Re-arming it after a clear catches a promotion flag that is never dropped. Pulsing every source with all enables clear, a pulse that collides with a clearing write, dropping an enable while its flag is set, and a strobe that coincides with the event pulse each isolate one of the gating, priority and ordering rules.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned SRC_CNT    = 6;
  localparam int unsigned SRC_XFER   = 0;
  localparam int unsigned SRC_BUSERR = 1;
  localparam int unsigned SRC_PORT   = 2;
  localparam int unsigned SRC_ROLL   = 3;
  localparam int unsigned SRC_SYSERR = 4;
  localparam int unsigned SRC_ASYNC  = 5;
  // Sources that wait for the threshold strobe (R5)
  localparam logic [SRC_CNT-1:0] DEFER_CLASS =
    SRC_CNT'((1 << SRC_ASYNC) | (1 << SRC_BUSERR) | (1 << SRC_XFER));
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_nxt;
  logic [N-1:0] stat_upd;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      stat_upd[g] = evt_i[g] | (clr_en_i & clr_mask_i[g]);
      // a set pulse outranks a clearing write in the same cycle
      stat_nxt[g] = evt_i[g] | (stat_q[g] & ~(clr_en_i & clr_mask_i[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           stat_q[g] <= 1'b0;
      else if (stat_upd[g]) stat_q[g] <= stat_nxt[g];
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[g] && clr_en_i && clr_mask_i[g]) |=> stat_q[g]);
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !(clr_en_i && clr_mask_i[g])) |=> stat_q[g]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] en_nxt;

  always_comb en_nxt = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= en_nxt;
  end

  p_en_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(en_q));

  assign en_o = en_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned N = 6,
  parameter logic [N-1:0] DEFER = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic         thresh_i,
  output logic         irq_o
);
  logic [N-1:0] hit_imm;
  logic [N-1:0] hit_def;
  logic         any_imm;
  logic         any_def;
  logic         armed_q;
  logic         armed_nxt;
  logic         irq_q;
  logic         irq_nxt;

  for (genvar g = 0; g < N; g++) begin : g_src
    if (DEFER[g]) begin : g_def
      assign hit_def[g] = stat_i[g] & en_i[g];
      assign hit_imm[g] = 1'b0;
    end else begin : g_imm
      assign hit_imm[g] = stat_i[g] & en_i[g];
      assign hit_def[g] = 1'b0;
    end
  end

  always_comb begin
    any_imm   = |hit_imm;
    any_def   = |hit_def;
    // promoted on the strobe, held while any enabled deferred flag remains
    armed_nxt = any_def & (thresh_i | armed_q);
    irq_nxt   = any_imm | armed_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
      irq_q   <= irq_nxt;
    end
  end

  p_armed_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_def |=> !armed_q);

  assign irq_o = irq_q;
endmodule

// File: rtl/usb_host_irq_ctrl.sv
module usb_host_irq_ctrl #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned STAT_ADDR = 0,
  parameter int unsigned ENAB_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        evt_i,
  input  logic              thresh_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  import usb_irq_pkg::*;
  localparam int unsigned N = SRC_CNT;

  logic [N-1:0]        stat;
  logic [N-1:0]        en;
  logic                sel_stat;
  logic                sel_enab;
  logic [DATA_W-N-1:0] wdata_unused;

  assign wdata_unused = bus_wdata_i[DATA_W-1:N];
  assign sel_stat = (bus_addr_i == ADDR_W'(STAT_ADDR));
  assign sel_enab = (bus_addr_i == ADDR_W'(ENAB_ADDR));

  irq_status_bank #(.N(N)) i_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .clr_en_i(bus_wr_i & sel_stat), .clr_mask_i(bus_wdata_i[N-1:0]),
    .stat_o(stat)
  );

  irq_enable_reg #(.N(N)) i_enab (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_i & sel_enab),
    .wdata_i(bus_wdata_i[N-1:0]), .en_o(en)
  );

  irq_gate #(.N(N), .DEFER(DEFER_CLASS)) i_gate (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .en_i(en),
    .thresh_i(thresh_i), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel_stat)      bus_rdata_o[N-1:0] = stat;
    else if (sel_enab) bus_rdata_o[N-1:0] = en;
  end

  always_comb begin
    if (rst_n) begin
      p_rsvd_zero_r2: assert (bus_rdata_o[DATA_W-1:N] == '0);
    end
  end

  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) == '0) |=> !irq_o);
  p_imm_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en & ~DEFER_CLASS) != '0) |=> irq_o);
  p_defer_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !thresh_i && ((stat & en & ~DEFER_CLASS) == '0)) |=> !irq_o);
  p_defer_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh_i && ((stat & en & DEFER_CLASS) != '0)) |=> irq_o);
endmodule

// File: tb/test_usb_host_irq_ctrl.sv
module test_usb_host_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [5:0]  evt_i;
  logic        thresh_i;
  logic        bus_wr_i;
  logic [3:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  usb_host_irq_ctrl i_usb_host_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .thresh_i(thresh_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    tick(1);
    bus_wr_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic pulse(logic [5:0] e);
    evt_i = e; tick(1); evt_i = '0;
  endtask

  task automatic strobe();
    thresh_i = 1'b1; tick(1); thresh_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(4'd0, d); check("R2 status after reset", d, 32'h0);
    reg_read(4'd1, d); check("R2 enable after reset", d, 32'h0);
    check("R2 irq after reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    reg_write(4'd1, 32'hFFFF_FFFF);
    reg_read(4'd1, d); check("R1 R2 enable readback", d, 32'h3F);
    reg_write(4'd1, 32'h0000_0015);
    reg_read(4'd1, d); check("R1 enable pattern", d, 32'h15);
    reg_write(4'd1, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    pulse(6'h3F);
    tick(3);
    check("R3 no irq with enables clear", {31'b0, irq_o}, 32'h0);
    reg_read(4'd0, d); check("R4 all status set", d, 32'h3F);
    reg_write(4'd0, 32'h0000_0005);
    reg_read(4'd0, d); check("R4 partial w1c", d, 32'h3A);
    reg_write(4'd0, 32'hFFFF_FFFF);
    reg_read(4'd0, d); check("R4 full w1c", d, 32'h0);
  endtask

  task automatic t_immediate();
    for (int i = 2; i <= 4; i++) begin
      reg_write(4'd1, 32'(1 << i));
      pulse(6'(1 << i));
      check("R6 irq not yet after one edge", {31'b0, irq_o}, 32'h0);
      tick(1);
      check("R6 immediate irq", {31'b0, irq_o}, 32'h1);
      tick(3);
      check("R7 immediate irq held", {31'b0, irq_o}, 32'h1);
      reg_write(4'd0, 32'(1 << i));
      check("R7 irq one edge after clear", {31'b0, irq_o}, 32'h1);
      tick(1);
      check("R7 irq dropped after clear", {31'b0, irq_o}, 32'h0);
    end
    reg_write(4'd1, 32'h0);
  endtask

  task automatic t_deferred();
    for (int i = 0; i <= 5; i++) begin
      if (i == 0 || i == 1 || i == 5) begin
        reg_write(4'd1, 32'(1 << i));
        pulse(6'(1 << i));
        tick(4);
        check("R5 deferred waits for strobe", {31'b0, irq_o}, 32'h0);
        strobe();
        check("R5 deferred irq after strobe", {31'b0, irq_o}, 32'h1);
        tick(3);
        check("R7 deferred irq held", {31'b0, irq_o}, 32'h1);
        reg_write(4'd0, 32'(1 << i));
        tick(1);
        check("R7 deferred irq dropped", {31'b0, irq_o}, 32'h0);
        pulse(6'(1 << i));
        tick(3);
        check("R8 re-arm needs new strobe", {31'b0, irq_o}, 32'h0);
        strobe();
        check("R8 re-armed irq", {31'b0, irq_o}, 32'h1);
        reg_write(4'd0, 32'h3F);
        tick(1);
      end
    end
    reg_write(4'd1, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(6'h01);
    evt_i = 6'h04; bus_wr_i = 1'b1; bus_addr_i = 4'd0; bus_wdata_i = 32'h05;
    tick(1);
    evt_i = '0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    reg_read(4'd0, d); check("R4 set wins over clear", d, 32'h04);
    reg_write(4'd0, 32'h3F);
  endtask

  task automatic t_enable_drop();
    logic [31:0] d;
    reg_write(4'd1, 32'h08);
    pulse(6'h08);
    tick(1);
    check("R6 rollover irq", {31'b0, irq_o}, 32'h1);
    reg_write(4'd1, 32'h0);
    tick(1);
    check("R3 irq drops with enable", {31'b0, irq_o}, 32'h0);
    reg_read(4'd0, d); check("R3 status kept", d, 32'h08);
    reg_write(4'd1, 32'h08);
    tick(1);
    check("R3 irq back on re-enable", {31'b0, irq_o}, 32'h1);
    reg_write(4'd0, 32'h3F);
    reg_write(4'd1, 32'h0);
    tick(1);
  endtask

  task automatic t_strobe_same_cycle();
    reg_write(4'd1, 32'h01);
    evt_i = 6'h01; thresh_i = 1'b1;
    tick(1);
    evt_i = '0; thresh_i = 1'b0;
    tick(3);
    check("R5 coincident strobe ignored", {31'b0, irq_o}, 32'h0);
    strobe();
    check("R5 later strobe promotes", {31'b0, irq_o}, 32'h1);
    reg_write(4'd0, 32'h3F);
    reg_write(4'd1, 32'h0);
    tick(1);
  endtask

  initial begin
    rst_n = 1'b0; evt_i = '0; thresh_i = 1'b0;
    bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_enable_rw();
    t_disabled();
    t_immediate();
    t_deferred();
    t_set_wins();
    t_enable_drop();
    t_strobe_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule